// File: doc/BRIEF.md
# Cumulative Rank Boundary Decoder

This block turns a physical byte address into the DRAM rank and channel that hold it, for a memory controller with two channels of four ranks each. Software programs, through a small write port, an 8-bit cumulative upper limit for every rank, counted in 32 MiB units, and a 3-bit page-size code for every rank. From these settings the block works out on its own whether the two channels are populated identically. If they are, it interleaves them. If they are not, it runs them as one asymmetric address space.

For every address presented, the block finds the lowest rank whose limit lies above the address. It reports whether that rank is really populated, and if so its rank index, the channel and the rank's page-size code. The lookup is combinational and is followed by one register stage, so results appear one clock after the address. A separate flag reports any rank that carries a reserved page-size code.

Top module: `rbd_decoder`

## Requirements
- R1: After reset every stored limit and code is zero. `hit_o`, `rank_o`, `chan_o`, `page_o` and `cfg_err_o` are 0, and `ilv_o` is 1 because the two empty channels match.
- R2: Writes use these `wr_sel_i` values:
  - 0..3 set the limits of channel 0 ranks 0..3.
  - 4..7 set the limits of channel 1 ranks 0..3.
  - 8 and 9 set the channel 0 codes for ranks 0/1 and 2/3.
  - 10 and 11 set the channel 1 codes for ranks 0/1 and 2/3.
  - In a code byte, bits 2:0 belong to the even rank of the pair and bits 6:4 to the odd rank. Bits 3 and 7 are discarded.
- R3: The address is compared in 32 MiB units, using address bits 33:25. The selected rank is the lowest one whose scaled limit is strictly greater than that value.
- R4: A rank whose limit equals the limit of the rank before it holds no memory and is never reported. For rank 0 the previous limit is zero, or the channel's starting offset.
- R5: Page-size codes are 3'b010 = 4 KB, 3'b011 = 8 KB and 3'b100 = 16 KB. On a hit, `page_o` carries the selected rank's code.
- R6: A rank coded 3'b000 or a reserved code (3'b001, 3'b101, 3'b110, 3'b111) counts as unpopulated and gives a miss. `cfg_err_o` is 1 while any rank holds a reserved code.
- R7: Interleaving:
  - `ilv_o` is 1 exactly when every limit and every code of channel 1 equals that of the same rank in channel 0.
  - While it is 1, only the channel 0 limits are used, each doubled.
  - `chan_o` then copies address bit 7.
- R8: Asymmetric mode (`ilv_o` 0): channel 0 ranks occupy the low addresses. Channel 1 limits are offset by the last channel 0 limit, and `chan_o` names the channel that owns the rank.
- R9: An address at or above the total memory, or one that selects an unpopulated rank, gives `hit_o` 0 with `rank_o`, `chan_o` and `page_o` all 0.
- R10: Results appear exactly one clock after the address. A write in the same cycle as a lookup does not affect that lookup, only later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 4 | Configuration byte select |
| wr_data_i | input | 8 | Configuration write data |
| addr_i | input | 34 | Physical byte address to decode |
| hit_o | output | 1 | Address falls in a populated rank |
| rank_o | output | 2 | Rank index within its channel |
| chan_o | output | 1 | Channel of the access |
| page_o | output | 3 | Page-size code of the selected rank |
| ilv_o | output | 1 | Channels are interleaved |
| cfg_err_o | output | 1 | A reserved page-size code is programmed |

## Verification
A configuration write and an address lookup can land in the same clock. The write changes the limits at the same edge that captures the decode result. The bench provokes this by driving a write that moves a rank boundary together with an address lying in the moved range. It expects the result computed from the old configuration, then repeats the address and expects the new mapping in the following cycle.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  localparam int unsigned CH_N        = 2;
  localparam int unsigned RK_PER_CH   = 4;
  localparam int unsigned BND_W       = 8;
  localparam int unsigned GRAIN_SHIFT = 25;
  localparam int unsigned ILV_BIT     = 7;
  localparam int unsigned SEL_W       = 4;

  localparam logic [2:0] PG_NONE = 3'b000;
  localparam logic [2:0] PG_4K   = 3'b010;
  localparam logic [2:0] PG_8K   = 3'b011;
  localparam logic [2:0] PG_16K  = 3'b100;

  function automatic logic page_ok(input logic [2:0] code);
    return (code == PG_4K) || (code == PG_8K) || (code == PG_16K);
  endfunction

  function automatic logic page_rsvd(input logic [2:0] code);
    return !page_ok(code) && (code != PG_NONE);
  endfunction

endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs #(
  parameter int unsigned CH  = rbd_pkg::CH_N,
  parameter int unsigned RPC = rbd_pkg::RK_PER_CH,
  parameter int unsigned BW  = rbd_pkg::BND_W,
  parameter int unsigned SW  = rbd_pkg::SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [SW-1:0]            wr_sel_i,
  input  logic [BW-1:0]            wr_data_i,
  output logic [CH*RPC-1:0][BW-1:0] bnd_o,
  output logic [CH*RPC-1:0][2:0]    attr_o
);

  localparam int unsigned NR = CH * RPC;
  localparam int unsigned NA = NR / 2;

  logic [NR-1:0][BW-1:0] bnd_q, bnd_d;
  logic [NR-1:0][2:0]    attr_q, attr_d;
  logic                  unused_rsvd_bits;

  assign unused_rsvd_bits = wr_data_i[3] ^ wr_data_i[BW-1];

  // next state: limit bytes first, then paired code bytes
  always_comb begin
    bnd_d  = bnd_q;
    attr_d = attr_q;
    if (wr_en_i) begin
      for (int i = 0; i < int'(NR); i++) begin
        if (wr_sel_i == SW'(i)) bnd_d[i] = wr_data_i;
      end
      for (int k = 0; k < int'(NA); k++) begin
        if (wr_sel_i == SW'(int'(NR) + k)) begin
          attr_d[2*k]   = wr_data_i[2:0];
          attr_d[2*k+1] = wr_data_i[6:4];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q  <= '0;
      attr_q <= '0;
    end else begin
      bnd_q  <= bnd_d;
      attr_q <= attr_d;
    end
  end

  assign bnd_o  = bnd_q;
  assign attr_o = attr_q;

  AST_WR_LIMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == '0) |=> (bnd_q[0] == $past(wr_data_i)));  // R2

endmodule

// File: rtl/rbd_mode.sv
module rbd_mode #(
  parameter int unsigned CH  = rbd_pkg::CH_N,
  parameter int unsigned RPC = rbd_pkg::RK_PER_CH,
  parameter int unsigned BW  = rbd_pkg::BND_W,
  parameter int unsigned LW  = BW + $clog2(CH)
) (
  input  logic [CH*RPC-1:0][BW-1:0] bnd_i,
  input  logic [CH*RPC-1:0][2:0]    attr_i,
  output logic                      ilv_o,
  output logic                      cfg_err_o,
  output logic [CH*RPC-1:0][LW-1:0] lim_o,
  output logic [CH*RPC-1:0]         pop_o,
  output logic [LW-1:0]             total_o
);

  localparam int unsigned NR = CH * RPC;

  logic [NR-1:0][LW-1:0] lim_asym, base_asym, lim_ilv, base_ilv, base_sel;
  logic [LW-1:0]         total_asym, off, prev;

  // interleave detection and reserved-code scan
  always_comb begin
    ilv_o     = 1'b1;
    cfg_err_o = 1'b0;
    for (int i = 0; i < int'(NR); i++) begin
      if (rbd_pkg::page_rsvd(attr_i[i])) cfg_err_o = 1'b1;
    end
    for (int c = 1; c < int'(CH); c++) begin
      for (int r = 0; r < int'(RPC); r++) begin
        if (bnd_i[c*RPC+r] != bnd_i[r] || attr_i[c*RPC+r] != attr_i[r]) ilv_o = 1'b0;
      end
    end
  end

  // asymmetric layout: channels stacked in order
  always_comb begin
    lim_asym  = '0;
    base_asym = '0;
    off       = '0;
    prev      = '0;
    for (int c = 0; c < int'(CH); c++) begin
      prev = off;
      for (int r = 0; r < int'(RPC); r++) begin
        lim_asym[c*RPC+r]  = off + LW'(bnd_i[c*RPC+r]);
        base_asym[c*RPC+r] = prev;
        prev               = lim_asym[c*RPC+r];
      end
      off = lim_asym[c*RPC+RPC-1];
    end
    total_asym = off;
  end

  // interleaved layout: channel 0 limits scaled by channel count
  always_comb begin
    lim_ilv  = '0;
    base_ilv = '0;
    for (int r = 0; r < int'(RPC); r++) begin
      lim_ilv[r]  = LW'(bnd_i[r]) * LW'(CH);
      base_ilv[r] = (r == 0) ? '0 : LW'(bnd_i[r-1]) * LW'(CH);
    end
  end

  always_comb begin
    lim_o    = ilv_o ? lim_ilv  : lim_asym;
    base_sel = ilv_o ? base_ilv : base_asym;
    total_o  = ilv_o ? LW'(bnd_i[RPC-1]) * LW'(CH) : total_asym;
    for (int i = 0; i < int'(NR); i++) begin
      pop_o[i] = rbd_pkg::page_ok(attr_i[i]) && (lim_o[i] > base_sel[i]);
    end
  end

endmodule

// File: rtl/rbd_lookup.sv
module rbd_lookup #(
  parameter int unsigned CH  = rbd_pkg::CH_N,
  parameter int unsigned RPC = rbd_pkg::RK_PER_CH,
  parameter int unsigned LW  = rbd_pkg::BND_W + $clog2(rbd_pkg::CH_N),
  localparam int unsigned CW = (CH > 1) ? $clog2(CH) : 1,
  localparam int unsigned RW = (RPC > 1) ? $clog2(RPC) : 1
) (
  input  logic [LW-1:0]             grain_i,
  input  logic [CW-1:0]             csel_i,
  input  logic                      ilv_i,
  input  logic [CH*RPC-1:0][LW-1:0] lim_i,
  input  logic [CH*RPC-1:0]         pop_i,
  input  logic [CH*RPC-1:0][2:0]    attr_i,
  output logic                      hit_o,
  output logic [RW-1:0]             rank_o,
  output logic [CW-1:0]             chan_o,
  output logic [2:0]                page_o
);

  localparam int unsigned NR = CH * RPC;
  localparam int unsigned IW = $clog2(NR);

  logic          found;
  logic [IW-1:0] sel;

  // lowest index whose limit lies above the address wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = int'(NR) - 1; i >= 0; i--) begin
      if (lim_i[i] > grain_i) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  always_comb begin
    hit_o  = found && pop_i[sel];
    rank_o = '0;
    chan_o = '0;
    page_o = '0;
    if (hit_o) begin
      rank_o = sel[RW-1:0];
      chan_o = ilv_i ? csel_i : sel[IW-1:RW];
      page_o = attr_i[sel];
    end
  end

endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder #(
  parameter int unsigned CH_N        = rbd_pkg::CH_N,
  parameter int unsigned RK_PER_CH   = rbd_pkg::RK_PER_CH,
  parameter int unsigned BND_W       = rbd_pkg::BND_W,
  parameter int unsigned GRAIN_SHIFT = rbd_pkg::GRAIN_SHIFT,
  parameter int unsigned ILV_BIT     = rbd_pkg::ILV_BIT,
  parameter int unsigned SEL_W       = rbd_pkg::SEL_W
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en_i,
  input  logic [SEL_W-1:0]                              wr_sel_i,
  input  logic [BND_W-1:0]                              wr_data_i,
  input  logic [GRAIN_SHIFT+BND_W+$clog2(CH_N)-1:0]     addr_i,
  output logic                                          hit_o,
  output logic [$clog2(RK_PER_CH)-1:0]                  rank_o,
  output logic [$clog2(CH_N)-1:0]                       chan_o,
  output logic [2:0]                                    page_o,
  output logic                                          ilv_o,
  output logic                                          cfg_err_o
);

  localparam int unsigned NR     = CH_N * RK_PER_CH;
  localparam int unsigned LW     = BND_W + $clog2(CH_N);
  localparam int unsigned ADDR_W = GRAIN_SHIFT + LW;
  localparam int unsigned CW     = $clog2(CH_N);
  localparam int unsigned RW     = $clog2(RK_PER_CH);

  logic [NR-1:0][BND_W-1:0] bnd;
  logic [NR-1:0][2:0]       attr;
  logic [NR-1:0][LW-1:0]    lim;
  logic [NR-1:0]            pop;
  logic [LW-1:0]            total;
  logic [LW-1:0]            grain;
  logic                     ilv;

  logic          hit_d, hit_q;
  logic [RW-1:0] rank_d, rank_q;
  logic [CW-1:0] chan_d, chan_q;
  logic [2:0]    page_d, page_q;
  logic          unused_addr_low;

  assign grain           = addr_i[ADDR_W-1:GRAIN_SHIFT];
  assign unused_addr_low = ^{addr_i[GRAIN_SHIFT-1:ILV_BIT+CW], addr_i[ILV_BIT-1:0]};

  rbd_cfg_regs #(.CH(CH_N), .RPC(RK_PER_CH), .BW(BND_W), .SW(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .bnd_o     (bnd),
    .attr_o    (attr)
  );

  rbd_mode #(.CH(CH_N), .RPC(RK_PER_CH), .BW(BND_W), .LW(LW)) u_mode (
    .bnd_i     (bnd),
    .attr_i    (attr),
    .ilv_o     (ilv),
    .cfg_err_o (cfg_err_o),
    .lim_o     (lim),
    .pop_o     (pop),
    .total_o   (total)
  );

  rbd_lookup #(.CH(CH_N), .RPC(RK_PER_CH), .LW(LW)) u_lookup (
    .grain_i (grain),
    .csel_i  (addr_i[ILV_BIT +: CW]),
    .ilv_i   (ilv),
    .lim_i   (lim),
    .pop_i   (pop),
    .attr_i  (attr),
    .hit_o   (hit_d),
    .rank_o  (rank_d),
    .chan_o  (chan_d),
    .page_o  (page_d)
  );

  // single output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      rank_q <= '0;
      chan_q <= '0;
      page_q <= '0;
    end else begin
      hit_q  <= hit_d;
      rank_q <= rank_d;
      chan_q <= chan_d;
      page_q <= page_d;
    end
  end

  assign hit_o  = hit_q;
  assign rank_o = rank_q;
  assign chan_o = chan_q;
  assign page_o = page_q;
  assign ilv_o  = ilv;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (rank_o == '0 && chan_o == '0 && page_o == '0));  // R9

  AST_HIT_PAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (page_o == 3'b010 || page_o == 3'b011 || page_o == 3'b100));  // R5

  AST_ABOVE_TOTAL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (grain >= total) |=> !hit_o);  // R9

  AST_ILV_CHAN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ilv && hit_d) |=> (chan_o == $past(addr_i[ILV_BIT +: CW])));  // R7

endmodule

// File: tb/sim_rbd_decoder.sv
module sim_rbd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [33:0] addr_i = '0;
  logic        hit_o;
  logic [1:0]  rank_o;
  logic        chan_o;
  logic [2:0]  page_o;
  logic        ilv_o;
  logic        cfg_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  int         mb [2][4];
  logic [2:0] ma [2][4];

  always #2 clk = ~clk;

  rbd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .addr_i(addr_i), .hit_o(hit_o), .rank_o(rank_o),
    .chan_o(chan_o), .page_o(page_o), .ilv_o(ilv_o), .cfg_err_o(cfg_err_o)
  );

  function automatic bit code_ok(logic [2:0] c);
    return c == 3'b010 || c == 3'b011 || c == 3'b100;
  endfunction

  function automatic bit ref_ilv();
    for (int r = 0; r < 4; r++)
      if (mb[0][r] != mb[1][r] || ma[0][r] != ma[1][r]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ref_err();
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++)
        if (!code_ok(ma[c][r]) && ma[c][r] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  // expected {hit, rank[1:0], chan, page[2:0]}
  function automatic logic [6:0] ref_dec(logic [33:0] a);
    int g, off, prev, lim;
    g = int'(a[33:25]);
    if (ref_ilv()) begin
      prev = 0;
      for (int r = 0; r < 4; r++) begin
        lim = 2 * mb[0][r];
        if (lim > g)
          return (code_ok(ma[0][r]) && lim > prev) ? {1'b1, 2'(r), a[7], ma[0][r]} : 7'd0;
        prev = lim;
      end
      return 7'd0;
    end
    off = 0;
    for (int c = 0; c < 2; c++) begin
      prev = off;
      for (int r = 0; r < 4; r++) begin
        lim = off + mb[c][r];
        if (lim > g)
          return (code_ok(ma[c][r]) && lim > prev) ? {1'b1, 2'(r), 1'(c), ma[c][r]} : 7'd0;
        prev = lim;
      end
      off = off + mb[c][3];
    end
    return 7'd0;
  endfunction

  function automatic void model_wr(int sel, logic [7:0] d);
    int k;
    if (sel < 8) mb[sel/4][sel%4] = int'(d);
    else if (sel < 12) begin
      k = sel - 8;
      ma[k/2][2*(k%2)]   = d[2:0];
      ma[k/2][2*(k%2)+1] = d[6:4];
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [33:0] mk(int g, bit b7);
    logic [33:0] a;
    a = 34'(g) << 25;
    a[7] = b7;
    a[3] = 1'b1;
    return a;
  endfunction

  task automatic look(int g, bit b7, string tag);
    item_t it;
    @(negedge clk);
    addr_i = mk(g, b7);
    it.exp = ref_dec(addr_i);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(int sel, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 4'(sel); wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    model_wr(sel, d);
  endtask

  // write and lookup in the same cycle: lookup sees old configuration
  task automatic wr_look(int sel, logic [7:0] d, int g, string tag);
    item_t it;
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 4'(sel); wr_data_i = d;
    addr_i = mk(g, 1'b0);
    it.exp = ref_dec(addr_i);
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    model_wr(sel, d);
  endtask

  // monitor: one result per pushed lookup, one clock later
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, 32'({hit_o, rank_o, chan_o, page_o}), 32'(it.exp));
    end
  end

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) begin mb[c][r] = 0; ma[c][r] = 3'b000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", 32'({hit_o, rank_o, chan_o, page_o}), 32'd0);
    check("R1 ilv", 32'(ilv_o), 32'd1);
    check("R1 cfg_err", 32'(cfg_err_o), 32'd0);
    look(0, 1'b0, "R1 empty miss");

    // asymmetric: ch0 4,4,8,8 ; ch1 2,6,6,6 (R2 mapping)
    wr(0, 8'd4); wr(1, 8'd4); wr(2, 8'd8); wr(3, 8'd8);
    wr(4, 8'd2); wr(5, 8'd6); wr(6, 8'd6); wr(7, 8'd6);
    wr(8, 8'h8A);   // R2 bits 3,7 discarded: rank0 010, rank1 000
    wr(9, 8'h03); wr(10, 8'h24); wr(11, 8'h00);
    drain();
    check("R8 ilv low", 32'(ilv_o), 32'd0);
    check("R6 cfg clean", 32'(cfg_err_o), 32'd0);
    look(0, 1'b0, "R3 rank0 low");
    look(3, 1'b1, "R3 rank0 top");
    look(4, 1'b0, "R4 skip repeated rank1");
    look(7, 1'b0, "R5 rank2 8K");
    look(8, 1'b0, "R8 ch1 rank0 16K");
    look(9, 1'b1, "R8 ch1 rank0 top");
    look(10, 1'b0, "R8 ch1 rank1");
    look(13, 1'b0, "R8 ch1 rank1 top");
    look(14, 1'b0, "R9 at total");
    look(300, 1'b0, "R9 far above");
    drain();

    // R10: write moves ch0 rank0 limit 4->2 in the lookup cycle
    wr_look(0, 8'd2, 3, "R10 old config");
    look(3, 1'b0, "R10 new config");
    wr(0, 8'd4);
    drain();

    // interleave: make ch1 identical to ch0
    wr(4, 8'd4); wr(5, 8'd4); wr(6, 8'd8); wr(7, 8'd8);
    wr(10, 8'h02); wr(11, 8'h03);
    drain();
    check("R7 ilv high", 32'(ilv_o), 32'd1);
    look(0, 1'b0, "R7 rank0 ch0");
    look(7, 1'b1, "R7 doubled rank0 ch1");
    look(8, 1'b0, "R7 rank2 ch0");
    look(15, 1'b1, "R7 rank2 ch1");
    look(16, 1'b0, "R9 ilv total");
    drain();

    // reserved code on rank0 both channels, still interleaved
    wr(8, 8'h01); wr(10, 8'h01);
    drain();
    check("R6 cfg_err", 32'(cfg_err_o), 32'd1);
    check("R6 ilv kept", 32'(ilv_o), 32'd1);
    look(2, 1'b1, "R6 reserved miss");
    look(9, 1'b0, "R6 rank2 still hit");
    drain();
    wr(8, 8'h04); wr(10, 8'h04);
    drain();
    check("R6 cfg_err clear", 32'(cfg_err_o), 32'd0);
    look(2, 1'b1, "R5 16K rank0");
    drain();

    finish_run();
  end

endmodule